// File: doc/BRIEF.md
# Divide-by-Twelve Ripple Counter with Clear Hold

The block counts pulses on a single input and wraps from eleven back to zero. Four toggle stages form a ripple chain. The first stage changes state on each falling edge of the pulse input. Each later stage changes state on each falling edge of the stage below it. The whole chain is sampled on a fast clock, so the per-stage clock-to-output delay is a parameter measured in cycles of that clock. This lets the ripple, with unequal stage delays, be reproduced exactly in a synchronous netlist.

The count reaches twelve when the top two bits are both high. That condition sets a clear-hold register, and the register drives one common clear into all four stages. The hold is only let go once every stage output reads zero and the pulse input has returned low. No stage can therefore escape the clear because it is slower than the others.

The most significant bit is also brought out as a divided-by-twelve output. That output is high for four of every twelve input periods and low for eight. It is not a square wave, and this is intended.

The pulse input is expected to be synchronous to `clk`. A pulse counts once its falling edge is seen at a rising edge of `clk`.

Top module: `mr12_ripple_counter`

## Requirements
- R1: While `rst_n` is low, `count` and `div12` are 0, from the moment reset is applied and independent of `clk`. Internal release happens on a clock edge.
- R2: `count` is binary. Bit 0 is the first stage, which toggles on each falling edge of `pulse_in`. One counted falling edge moves a settled value of 0 to 1.
- R3: Stage k+1 toggles only when the output of stage k goes from 1 to 0. After n counted pulses, the settled value of `count` is n mod 12.
- R4: When bits 3 and 2 of `count` are both 1, the clear-hold register is set on the next edge and every stage returns to 0. The values 13, 14 and 15 never appear on `count`.
- R5: The clear stays asserted until `count` is 0 and `pulse_in` is low. A falling edge of `pulse_in` seen while the clear is asserted is not counted, and counting resumes with the next pulse.
- R6: `div12` equals bit 3 of `count`. Once settled, it is 1 for counts 8 to 11 and 0 for counts 0 to 7.
- R7: Each stage output lags its internal state by a parameter number of `clk` cycles (at least 1). With unequal delays, the settled count still follows R3.
- R8: While the clear is asserted, no bit of `count` goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all stages and the clear-hold register |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on `clk` |
| pulse_in | input | 1 | Pulses to be counted; the falling edge is active |
| count | output | 4 | Stage outputs, bit 0 from the first stage |
| div12 | output | 1 | Input pulse rate divided by twelve (most significant stage) |

## Verification
A stage that toggles on the wrong edge, or a missing link in the chain, shows up as a wrong settled count within one pulse period. A bad decode or a hold that releases too early shows up near the twelfth pulse. It appears as a settled value of 12, a value above 12, or a bit that rises again during the clear. A hold that ignores the pulse level can only be seen when a pulse is held high across the clear window. In that case the next falling edge is counted when it should be dropped, and the settled count reads 1 instead of 0 after that pulse.

// File: rtl/mr12_pkg.sv
package mr12_pkg;
  localparam int unsigned STAGES = 4;
  localparam int unsigned DLY_W  = 4;
  localparam int unsigned MSB    = STAGES - 1;
  typedef logic [STAGES-1:0] count_t;
  typedef logic [STAGES*DLY_W-1:0] dly_vec_t;
endpackage

// File: rtl/mr12_reset_sync.sv
module mr12_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/mr12_toggle_stage.sv
module mr12_toggle_stage #(
  parameter int unsigned DLY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_lvl,
  input  logic clr,
  output logic q
);
  logic           lvl_q;
  logic           state_q;
  logic           state_d;
  logic           state_en;
  logic           fall;
  logic [DLY-1:0] pipe_q;
  logic [DLY-1:0] pipe_d;

  // falling edge of this stage's own clock source
  assign fall     = lvl_q & ~clk_lvl;
  assign state_en = clr | fall;

  always_comb begin
    if (clr) state_d = 1'b0;
    else     state_d = ~state_q;
  end

  // output lag line: state reaches q after DLY cycles
  generate
    if (DLY == 1) begin : g_one
      assign pipe_d = state_q;
    end else begin : g_many
      assign pipe_d = {pipe_q[DLY-2:0], state_q};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      state_q <= 1'b0;
      pipe_q  <= '0;
    end else begin
      lvl_q  <= clk_lvl;
      pipe_q <= pipe_d;
      if (state_en) state_q <= state_d;
    end
  end

  assign q = pipe_q[DLY-1];
endmodule

// File: rtl/mr12_clear_latch.sv
module mr12_clear_latch
  import mr12_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  count_t q,
  input  logic   pulse_lvl,
  output logic   clr,
  output logic   hold
);
  logic term;
  logic idle;
  logic hold_q;
  logic hold_d;

  // only the two top bits are decoded; 12..15 all trigger
  assign term = q[MSB] & q[MSB-1];
  assign idle = (q == '0) & ~pulse_lvl;

  always_comb begin
    hold_d = hold_q;
    if (term)      hold_d = 1'b1;
    else if (idle) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign clr  = term | hold_q;
  assign hold = hold_q;
endmodule

// File: rtl/mr12_ripple_counter.sv
module mr12_ripple_counter
  import mr12_pkg::*;
#(
  parameter dly_vec_t STAGE_DLY = {4'd4, 4'd1, 4'd3, 4'd2}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pulse_in,
  output logic [STAGES-1:0]   count,
  output logic                div12
);
  logic   rst_sync_n;
  count_t q_w;
  count_t src_w;
  logic   clr_w;
  logic   hold_w;

  mr12_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // each stage is clocked by the stage below; the first by the pulse input
  assign src_w = {q_w[STAGES-2:0], pulse_in};

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      localparam int unsigned DLY_I = int'(STAGE_DLY[i*DLY_W +: DLY_W]);
      mr12_toggle_stage #(.DLY(DLY_I)) u_tff (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .clk_lvl (src_w[i]),
        .clr     (clr_w),
        .q       (q_w[i])
      );
    end
  endgenerate

  mr12_clear_latch u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .q         (q_w),
    .pulse_lvl (pulse_in),
    .clr       (clr_w),
    .hold      (hold_w)
  );

  assign count = q_w;
  assign div12 = q_w[MSB];
endmodule

// File: rtl/mr12_checker.sv
module mr12_checker
  import mr12_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   pulse_in,
  input count_t count,
  input logic   clr,
  input logic   hold
);
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (count == '0));

  p_no_upper_states_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count < 4'd13);

  p_decode_sets_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count[MSB] && count[MSB-1]) |=> hold);

  p_hold_while_pulse_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && pulse_in) |=> hold);

  p_release_needs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> ($past(count) == '0 && !$past(pulse_in)));

  p_no_rise_in_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((count & ~$past(count)) == '0));
endmodule

bind mr12_ripple_counter mr12_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pulse_in (pulse_in),
  .count    (count),
  .clr      (clr_w),
  .hold     (hold_w)
);

// File: tb/mr12_ripple_counter_bench.sv
module mr12_ripple_counter_bench;
  localparam int SETTLE = 24;

  logic       clk;
  logic       rst_n;
  logic       pulse_in;
  logic [3:0] count;
  logic       div12;

  int checks;
  int errors;
  bit done;
  bit drop_next;

  // reference model state
  int       n_ref;
  int       since;
  bit       prev_pulse;
  bit       clearing;
  logic [3:0] prev_count;

  mr12_ripple_counter u_mr12_ripple_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_in (pulse_in),
    .count    (count),
    .div12    (div12)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock reference model, sampled at the falling clock edge
  always @(negedge clk) begin
    if (!rst_n) begin
      n_ref      = 0;
      since      = SETTLE;
      prev_pulse = 1'b0;
      clearing   = 1'b0;
      prev_count = 4'd0;
      check(count == 4'd0 && div12 == 1'b0, "R1 count in reset", int'(count), 0);
    end else begin
      if (prev_pulse && !pulse_in) begin
        if (drop_next) drop_next = 1'b0;
        else           n_ref = (n_ref + 1) % 12;
        since = 0;
      end else if (since < 1000) begin
        since++;
      end
      prev_pulse = pulse_in;
      check(count < 4'd13, "R4 no value above 12", int'(count), 12);
      if (since >= SETTLE) begin
        check(int'(count) == n_ref, "R3/R7 settled count", int'(count), n_ref);
        check(div12 == (n_ref >= 8), "R6 div12 level", int'(div12), int'(n_ref >= 8));
      end
      if (clearing)
        check((count & ~prev_count) == 4'd0, "R8 bit rose during clear",
              int'(count), int'(prev_count));
      if (count[3:2] == 2'b11) clearing = 1'b1;
      else if (count == 4'd0)  clearing = 1'b0;
      prev_count = count;
    end
  end

  task automatic pulse(input int hi, input int lo);
    @(posedge clk); #1 pulse_in = 1'b1;
    repeat (hi) @(posedge clk);
    #1 pulse_in = 1'b0;
    repeat (lo) @(posedge clk);
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) pulse(6, 30);
  endtask

  task automatic expect_count(input int exp, input string req);
    @(negedge clk);
    check(int'(count) == exp, req, int'(count), exp);
  endtask

  initial begin
    rst_n = 1'b1; pulse_in = 1'b0; drop_next = 1'b0;
    checks = 0; errors = 0; done = 1'b0;
    #1 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    expect_count(0, "R1 reset value");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);

    pulses(1);
    expect_count(1, "R2 first pulse");
    pulses(7);
    @(negedge clk);
    check(div12 == 1'b1, "R6 div12 high at 8", int'(div12), 1);
    pulses(4);
    expect_count(0, "R4 wrap after 12");
    pulses(36);
    expect_count(0, "R7 three more full cycles");
    pulses(5);
    expect_count(5, "R3 mid count");

    // pulse held high across the clear window: its falling edge is dropped
    pulses(6);
    expect_count(11, "R3 count 11");
    pulse(6, 1);
    @(posedge clk); #1 pulse_in = 1'b1; drop_next = 1'b1;
    repeat (40) @(posedge clk);
    #1 pulse_in = 1'b0;
    repeat (30) @(posedge clk);
    expect_count(0, "R5 edge during clear dropped");
    pulses(1);
    expect_count(1, "R5 counting resumes");

    // reset in the middle of a count
    pulses(3);
    expect_count(4, "R3 before reset");
    @(posedge clk); #1 rst_n = 1'b0;
    expect_count(0, "R1 async reset mid count");
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    pulses(3);
    expect_count(3, "R2 count after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule